// File: doc/BRIEF.md
# UART Interrupt Priority Identification

This block gathers the interrupt conditions of a 16550-style serial port and reports the most urgent one as a 4-bit identification code, along with a single interrupt line to the CPU. It owns two of the conditions. The first is the transmit-holding-empty condition, which is set when the holding register hands its byte to the shift register. The second is the modem-status-change condition, which is set when any of four modem control lines changes. The line-status and receive-data conditions come in as level inputs from neighbouring logic, and they outrank the two local conditions.

A small CPU register port gives read access to the identification code and to the modem status byte, and write access to the transmit holding register. A write to the holding register is passed straight on to the transmitter. Each local condition is cleared by its own access rule. The transmit-empty condition is also cleared by reading the identification code, but only when that read reports transmit-empty as the winner. Each of the four sources has its own enable bit. A disabled source still tracks its condition, but it neither wins the code nor raises the interrupt.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `irq_o` is 0. The identification code (read at the identification address, in `rdata[3:0]`) is 0001. The modem status byte reads 0x00.
- R2: When no enabled source is pending, the identification code is 0001 and `irq_o` is 0.
- R3: A pulse on `thr_empty_i` sets the transmit-empty condition. It reads as code 0010 when `ien_i[1]` is set and no higher source is enabled and pending.
- R4: A read of the identification address while the code is 0010 clears the transmit-empty condition at that clock edge.
- R5: A read of the identification address while a higher-priority code is reported leaves the transmit-empty condition set.
- R6: A write to the holding-register address clears the transmit-empty condition. In the same cycle, it drives `thr_load_o`=1 and `thr_data_o`=`wdata`.
- R7: Modem lines are registered once. A change on line i sets delta bit i on the next edge. The modem status byte holds the registered line states in bits 7:4 (line i at bit 4+i) and the deltas in bits 3:0. Any set delta with `ien_i[3]` gives code 0000 when nothing higher is pending.
- R8: A read of the modem status address clears all delta bits. A read of the identification address does not clear them.
- R9: The fixed priority order is: line status (`ls_irq_i`, enable bit 2, code 0110), then receive data (`rx_irq_i`, enable bit 0, code 0100), then transmit-empty (enable bit 1, code 0010), then modem status (enable bit 3, code 0000).
- R10: `irq_o` is 1 exactly when some source is both pending and enabled. Disabling a source removes it from both `irq_o` and the code.
- R11: A set event has priority over a clear in the same cycle. This holds for the transmit-empty condition (`thr_empty_i` together with a write or read clear) and for the delta bits (a line change together with a modem status read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ien_i | input | 4 | Source enables: bit0 receive, bit1 transmit-empty, bit2 line status, bit3 modem |
| ls_irq_i | input | 1 | Line-status condition pending (level) |
| rx_irq_i | input | 1 | Receive-data condition pending (level) |
| thr_empty_i | input | 1 | One-cycle pulse: holding register moved to shift register |
| modem_i | input | 4 | Raw modem control lines |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| addr | input | 3 | CPU register address |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, combinational on `addr` |
| thr_load_o | output | 1 | Holding-register write strobe to the transmitter |
| thr_data_o | output | 8 | Holding-register write data |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that `thr_empty_i` is a single-cycle pulse and that `ls_irq_i` and `rx_irq_i` are steady levels between clock edges. They also assume that the modem lines are held at 0 across reset, so that no change is seen on the first edge. The stimulus changes every input one time unit after a rising edge. It raises each modem line only after the deltas have been cleared, and it lets each change settle for two edges before it looks at the code. The sweep builds every mix of the four pending conditions under every enable pattern. It reads the code without a read strobe, so that the observation cannot clear the condition being observed.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      IID_LINE  = 4'b0110,
      IID_RXD   = 4'b0100,
      IID_TXE   = 4'b0010,
      IID_MODEM = 4'b0000,
      IID_IDLE  = 4'b0001
   } iid_e;

   localparam int unsigned EN_RXD   = 0;
   localparam int unsigned EN_TXE   = 1;
   localparam int unsigned EN_LINE  = 2;
   localparam int unsigned EN_MODEM = 3;

endpackage

// File: rtl/uart_irq_modem_delta.sv
module uart_irq_modem_delta #(
   parameter int unsigned LINES       = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] line_i,
   input  logic             rd_clr_i,
   output logic [LINES-1:0] state_o,
   output logic [LINES-1:0] delta_o
);

   logic [LINES-1:0] stage_q [SYNC_STAGES];
   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] delta_q;
   logic [LINES-1:0] change;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[0] <= '0;
            else        stage_q[0] <= line_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign state_o = stage_q[SYNC_STAGES-1];
   assign change  = state_o ^ prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         delta_q <= '0;
      end else begin
         prev_q  <= state_o;
         delta_q <= (delta_q & {LINES{~rd_clr_i}}) | change;
      end
   end

   assign delta_o = delta_q;

   assert_delta_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_clr_i |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

   assert_delta_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clr_i && state_o == prev_q) |=> delta_q == '0);

   assert_delta_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o != prev_q) |=> ((delta_q & $past(change)) == $past(change)));

endmodule

// File: rtl/uart_irq_txe_flag.sv
module uart_irq_txe_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_clr_i,
   input  logic rd_clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    flag_q <= 1'b0;
      else if (set_i)                flag_q <= 1'b1;
      else if (wr_clr_i || rd_clr_i) flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   assert_txe_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);

   assert_txe_wr_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr_i && !set_i) |=> !flag_q);

   assert_txe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !wr_clr_i && !rd_clr_i) |=> $stable(flag_q));

endmodule

// File: rtl/uart_irq_prio_enc.sv
module uart_irq_prio_enc
   import uart_irq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic line_req_i,
   input  logic rxd_req_i,
   input  logic txe_req_i,
   input  logic modem_req_i,
   output iid_e code_o
);

   always_comb begin
      if (line_req_i)       code_o = IID_LINE;
      else if (rxd_req_i)   code_o = IID_RXD;
      else if (txe_req_i)   code_o = IID_TXE;
      else if (modem_req_i) code_o = IID_MODEM;
      else                  code_o = IID_IDLE;
   end

   assert_line_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      line_req_i |-> code_o == IID_LINE);

   assert_rxd_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_req_i && rxd_req_i) |-> code_o == IID_RXD);

   assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_req_i || rxd_req_i || txe_req_i || modem_req_i) |-> code_o == IID_IDLE);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LINES       = 4,
   parameter int unsigned SYNC_STAGES = 1,
   parameter int unsigned THR_ADDR    = 0,
   parameter int unsigned IIR_ADDR    = 2,
   parameter int unsigned MSR_ADDR    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        ien_i,
   input  logic              ls_irq_i,
   input  logic              rx_irq_i,
   input  logic              thr_empty_i,
   input  logic [LINES-1:0]  modem_i,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              thr_load_o,
   output logic [DATA_W-1:0] thr_data_o,
   output logic              irq_o
);

   localparam int unsigned MSR_W = 2 * LINES;

   if (LINES < 1 || MSR_W > DATA_W) begin : g_bad_lines
      $error("uart_irq_ident: status byte does not fit DATA_W");
   end
   if (DATA_W < 4) begin : g_bad_data
      $error("uart_irq_ident: DATA_W too narrow for the code");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("uart_irq_ident: SYNC_STAGES out of range");
   end
   if (THR_ADDR == IIR_ADDR || IIR_ADDR == MSR_ADDR) begin : g_bad_map
      $error("uart_irq_ident: register addresses collide");
   end

   logic             sel_thr, sel_iir, sel_msr;
   logic             iir_rd, msr_rd;
   logic             txe_flag;
   logic [LINES-1:0] modem_state, modem_delta;
   logic             line_pend, rxd_pend, txe_pend, modem_pend;
   iid_e             code;

   assign sel_thr = (addr == ADDR_W'(THR_ADDR));
   assign sel_iir = (addr == ADDR_W'(IIR_ADDR));
   assign sel_msr = (addr == ADDR_W'(MSR_ADDR));
   assign iir_rd  = rd_en && sel_iir;
   assign msr_rd  = rd_en && sel_msr;

   assign thr_load_o = wr_en && sel_thr;
   assign thr_data_o = wdata;

   uart_irq_txe_flag u_txe (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (thr_empty_i),
      .wr_clr_i (thr_load_o),
      .rd_clr_i (iir_rd && code == IID_TXE),
      .flag_o   (txe_flag)
   );

   uart_irq_modem_delta #(
      .LINES       (LINES),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_modem (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_i   (modem_i),
      .rd_clr_i (msr_rd),
      .state_o  (modem_state),
      .delta_o  (modem_delta)
   );

   assign line_pend  = ls_irq_i     && ien_i[EN_LINE];
   assign rxd_pend   = rx_irq_i     && ien_i[EN_RXD];
   assign txe_pend   = txe_flag     && ien_i[EN_TXE];
   assign modem_pend = (|modem_delta) && ien_i[EN_MODEM];

   uart_irq_prio_enc u_enc (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_req_i  (line_pend),
      .rxd_req_i   (rxd_pend),
      .txe_req_i   (txe_pend),
      .modem_req_i (modem_pend),
      .code_o      (code)
   );

   assign irq_o = line_pend || rxd_pend || txe_pend || modem_pend;

   always_comb begin
      rdata = '0;
      if (sel_iir)      rdata = DATA_W'(code);
      else if (sel_msr) rdata = DATA_W'({modem_state, modem_delta});
   end

   assert_irq_vs_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (code != IID_IDLE));

   assert_txe_read_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && code == IID_TXE && !thr_empty_i) |=> !txe_flag);

   assert_txe_read_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && (code == IID_LINE || code == IID_RXD) && txe_flag) |=> txe_flag);

   assert_modem_iir_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && !msr_rd && (|modem_delta)) |=> (|modem_delta));

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

   localparam int unsigned THR_A = 0;
   localparam int unsigned IIR_A = 2;
   localparam int unsigned MSR_A = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ien_i = '0;
   logic       ls_irq_i = 1'b0;
   logic       rx_irq_i = 1'b0;
   logic       thr_empty_i = 1'b0;
   logic [3:0] modem_i = '0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       thr_load_o;
   logic [7:0] thr_data_o;
   logic       irq_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_irq_ident u_dut (
      .clk(clk), .rst_n(rst_n), .ien_i(ien_i), .ls_irq_i(ls_irq_i),
      .rx_irq_i(rx_irq_i), .thr_empty_i(thr_empty_i), .modem_i(modem_i),
      .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .thr_load_o(thr_load_o), .thr_data_o(thr_data_o),
      .irq_o(irq_o)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic peek(input int a, output logic [7:0] v);
      rd_en = 1'b0;
      addr  = 3'(a);
      #1;
      v = rdata;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      addr  = 3'(a);
      rd_en = 1'b1;
      #1;
      v = rdata;
      tick();
      rd_en = 1'b0;
   endtask

   task automatic wr_thr(input logic [7:0] d);
      addr  = 3'(THR_A);
      wdata = d;
      wr_en = 1'b1;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic pulse_empty();
      thr_empty_i = 1'b1;
      tick();
      thr_empty_i = 1'b0;
   endtask

   function automatic int exp_code(input logic [3:0] en, input bit ls, input bit rx,
                                   input bit tx, input bit ms);
      if (ls && en[2]) return 6;
      if (rx && en[0]) return 4;
      if (tx && en[1]) return 2;
      if (ms && en[3]) return 0;
      return 1;
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] lines;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // R1: reset state
      peek(IIR_A, v);
      check("R1 iir", int'(v), 1);
      check("R1 irq", int'(irq_o), 0);
      peek(MSR_A, v);
      check("R1 msr", int'(v), 0);

      // R2 R3 R9 R10: sweep of enables against every pending mix
      for (int en = 0; en < 16; en++) begin
         for (int p = 0; p < 16; p++) begin
            ien_i = '0; ls_irq_i = 1'b0; rx_irq_i = 1'b0;
            wr_thr(8'h00);
            rd(MSR_A, v);
            if (p[2]) pulse_empty();
            if (p[3]) begin
               modem_i[0] = ~modem_i[0];
               tick(); tick();
            end
            ien_i    = 4'(en);
            ls_irq_i = p[0];
            rx_irq_i = p[1];
            peek(IIR_A, v);
            check("R9 sweep code", int'(v[3:0]), exp_code(4'(en), p[0], p[1], p[2], p[3]));
            check("R10 sweep irq", int'(irq_o),
                  int'(exp_code(4'(en), p[0], p[1], p[2], p[3]) != 1));
         end
      end
      ien_i = '0; ls_irq_i = 1'b0; rx_irq_i = 1'b0;
      wr_thr(8'h00);
      rd(MSR_A, v);
      modem_i = '0;
      tick(); tick();
      rd(MSR_A, v);
      ien_i = 4'hF;
      peek(IIR_A, v);
      check("R2 idle", int'(v), 1);
      check("R2 irq", int'(irq_o), 0);

      // R5: read while line status reported keeps transmit-empty
      pulse_empty();
      ls_irq_i = 1'b1;
      rd(IIR_A, v);
      check("R5 read code", int'(v[3:0]), 6);
      ls_irq_i = 1'b0;
      peek(IIR_A, v);
      check("R5 txe kept", int'(v[3:0]), 2);

      // R4: read while transmit-empty reported clears it
      rd(IIR_A, v);
      check("R4 read code", int'(v[3:0]), 2);
      peek(IIR_A, v);
      check("R4 cleared", int'(v[3:0]), 1);
      check("R4 irq", int'(irq_o), 0);

      // R6: holding register write
      pulse_empty();
      addr = 3'(THR_A); wdata = 8'hA5; wr_en = 1'b1;
      #1;
      check("R6 load", int'(thr_load_o), 1);
      check("R6 data", int'(thr_data_o), 8'hA5);
      tick();
      wr_en = 1'b0;
      peek(IIR_A, v);
      check("R6 cleared", int'(v[3:0]), 1);

      // R11: set beats write clear
      addr = 3'(THR_A); wr_en = 1'b1; thr_empty_i = 1'b1;
      tick();
      wr_en = 1'b0; thr_empty_i = 1'b0;
      peek(IIR_A, v);
      check("R11 txe set wins", int'(v[3:0]), 2);
      wr_thr(8'h00);

      // R7 R8: each modem line in turn
      ien_i = 4'b1000;
      lines = '0;
      for (int i = 0; i < 4; i++) begin
         modem_i[i] = 1'b1;
         lines[i] = 1'b1;
         tick(); tick();
         peek(IIR_A, v);
         check("R7 modem code", int'(v[3:0]), 0);
         if (i == 0) begin
            rd(IIR_A, v);
            peek(IIR_A, v);
            check("R8 iir read keeps delta", int'(v[3:0]), 0);
         end
         rd(MSR_A, v);
         check("R7 msr", int'(v), int'({lines, 4'(1 << i)}));
         peek(MSR_A, v);
         check("R8 msr cleared", int'(v), int'({lines, 4'b0000}));
      end

      // R11: change detected on the same edge as a status read
      modem_i[2] = 1'b0;
      tick();
      rd(MSR_A, v);
      peek(MSR_A, v);
      check("R11 delta set wins", int'(v), int'({4'b1011, 4'b0100}));

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule